// File: doc/BRIEF.md
# I2C General-Call Software Reset Detector

This block sits behind a bit-level I2C front end and watches the bus events that the front end has already decoded: START, repeated START, STOP and received bytes. It recognises one exact transaction. That transaction is the general-call write address (all-zero address with the write direction, byte value 00h), then the reset command byte 06h, then STOP. When that transaction completes, the block asks the rest of the chip to return to its power-up state.

For every received byte the block gives the front end an acknowledge decision in the same cycle, so the front end can drive SDA during the ninth bit. When the transaction completes, the block raises a single-cycle reset request. It then keeps a busy flag high for a programmable number of clock cycles. While that flag is high, the general-call address is not acknowledged, so the device cannot be addressed while it is recovering.

A repeated START in place of the closing STOP abandons the attempt. So does a wrong byte, or any byte after the accepted command. A plain START in any state restarts recognition from the address byte.

Top module: `gcr_detector`

## Requirements
- R1: Out of reset, no byte is acknowledged until a START or repeated START has been seen. A START or repeated START in any state makes the next valid byte be treated as the address byte.
- R2: The first byte after a START that equals 00h is acknowledged when busy is low.
- R3: An address byte of 01h (general call with the read direction) or any value other than 00h is not acknowledged. The attempt is dropped, so a following 06h is not acknowledged and a STOP gives no reset.
- R4: The byte after an acknowledged address is acknowledged only if it equals 06h. Any other value is not acknowledged and ends the attempt.
- R5: A STOP seen in the cycle after an acknowledged 06h byte, with no START or repeated START in the same cycle, makes the reset request high in the following clock cycle.
- R6: A repeated START after the acknowledged 06h cancels the attempt and no reset request follows. A START or repeated START in the same cycle as STOP takes priority over the STOP.
- R7: Any byte that arrives after the acknowledged 06h is not acknowledged, and a later STOP gives no reset request.
- R8: The reset request is high for exactly one clock cycle per completed transaction.
- R9: The busy output rises together with the reset request and stays high for exactly HOLD_CYC cycles. While busy is high, a 00h address byte is not acknowledged.
- R10: The acknowledge output is high only in a cycle where the byte-valid input is high. It is decided combinationally in that same cycle.
- R11: A STOP outside a recognised transaction changes no output. It leaves the block waiting for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle strobe: START seen on the bus |
| bus_rstart | input | 1 | One-cycle strobe: repeated START seen |
| bus_stop | input | 1 | One-cycle strobe: STOP seen |
| rx_valid | input | 1 | One-cycle strobe: a full byte has been received |
| rx_byte | input | 8 | Received byte, valid while rx_valid is high |
| rx_ack | output | 1 | Acknowledge decision for the current byte |
| swrst_pulse | output | 1 | One-cycle software reset request |
| holdoff_busy | output | 1 | High during the post-reset hold-off window |

## Verification
The bench builds the block with HOLD_CYC set to 40. The production default is tens of thousands of cycles, so a window this short lets the bench watch the whole hold-off period end to end, many times over, within the run. It also lets random traffic land START and address bytes inside, at the edge of, and just after the busy window. With the short window, the blocked-acknowledge rule and the exact window length both get exercised repeatedly, alongside the repeated-START cancel and extra-byte abort paths.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ADDR  = 2'd1,
    S_CMD   = 2'd2,
    S_ARMED = 2'd3
  } gcr_state_e;

  localparam logic [7:0] GC_ADDR_WR = 8'h00;
  localparam logic [7:0] CMD_SWRST  = 8'h06;

  function automatic logic is_gc_write(input logic [7:0] b);
    return b == GC_ADDR_WR;
  endfunction

  function automatic logic is_reset_cmd(input logic [7:0] b);
    return b == CMD_SWRST;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/gcr_byte_judge.sv
module gcr_byte_judge
  import gcr_pkg::*;
(
  input  gcr_state_e state,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       busy,
  output logic       addr_ok,
  output logic       cmd_ok,
  output logic       ack
);

  // address accepted only when the hold-off window is closed
  assign addr_ok = (state == S_ADDR) && is_gc_write(rx_byte) && !busy;
  assign cmd_ok  = (state == S_CMD)  && is_reset_cmd(rx_byte);
  assign ack     = rx_valid && (addr_ok || cmd_ok);

endmodule

// File: rtl/gcr_seq.sv
module gcr_seq
  import gcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_any,
  input  logic       stop,
  input  logic       rx_valid,
  input  logic       addr_ok,
  input  logic       cmd_ok,
  output gcr_state_e state,
  output logic       fire,
  output logic       pulse
);

  gcr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start_any) begin
      state_d = S_ADDR;
    end else if (stop) begin
      state_d = S_IDLE;
    end else if (rx_valid) begin
      unique case (state_q)
        S_ADDR:  state_d = addr_ok ? S_CMD : S_IDLE;
        S_CMD:   state_d = cmd_ok ? S_ARMED : S_IDLE;
        S_ARMED: state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign fire  = stop && !start_any && (state_q == S_ARMED);
  assign state = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pulse   <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse   <= fire;
    end
  end

endmodule

// File: rtl/gcr_holdoff.sv
module gcr_holdoff #(
  parameter int unsigned HOLD_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int unsigned    CW     = gcr_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0]  LOAD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= LOAD_V;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/gcr_detector.sv
module gcr_detector #(
  parameter int unsigned HOLD_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_rstart,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       rx_ack,
  output logic       swrst_pulse,
  output logic       holdoff_busy
);

  import gcr_pkg::*;

  // named internal events, visible to the bound checker
  gcr_state_e seq_state;
  logic       start_any;
  logic       addr_ok;
  logic       cmd_ok;
  logic       fire_w;

  assign start_any = bus_start || bus_rstart;

  gcr_byte_judge u_judge (
    .state    (seq_state),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .busy     (holdoff_busy),
    .addr_ok  (addr_ok),
    .cmd_ok   (cmd_ok),
    .ack      (rx_ack)
  );

  gcr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_any (start_any),
    .stop      (bus_stop),
    .rx_valid  (rx_valid),
    .addr_ok   (addr_ok),
    .cmd_ok    (cmd_ok),
    .state     (seq_state),
    .fire      (fire_w),
    .pulse     (swrst_pulse)
  );

  gcr_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire_w),
    .busy  (holdoff_busy)
  );

endmodule

// File: rtl/gcr_chk.sv
module gcr_chk
  import gcr_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 50000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_start,
  input logic       bus_rstart,
  input logic       bus_stop,
  input logic       rx_valid,
  input logic       rx_ack,
  input logic       swrst_pulse,
  input logic       holdoff_busy,
  input gcr_state_e seq_state
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= 0;
    else if (swrst_pulse)  run_q <= 1;
    else if (holdoff_busy) run_q <= run_q + 1;
  end

  assert_ack_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> rx_valid);

  assert_stop_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !bus_start && !bus_rstart && seq_state == S_ARMED) |=> swrst_pulse);

  assert_rstart_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rstart |=> !swrst_pulse);

  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> !swrst_pulse);

  assert_busy_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |-> holdoff_busy);

  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdoff_busy) |-> (run_q == HOLD_CYC));

  assert_busy_blocks_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff_busy && seq_state == S_ADDR) |-> !rx_ack);

  assert_extra_byte_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == S_ARMED && rx_valid) |-> !rx_ack);

  assert_idle_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == S_IDLE) |-> !rx_ack);

endmodule

bind gcr_detector gcr_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_start    (bus_start),
  .bus_rstart   (bus_rstart),
  .bus_stop     (bus_stop),
  .rx_valid     (rx_valid),
  .rx_ack       (rx_ack),
  .swrst_pulse  (swrst_pulse),
  .holdoff_busy (holdoff_busy),
  .seq_state    (seq_state)
);

// File: tb/tb_gcr_detector.sv
`timescale 1ns/1ps
module tb_gcr_detector;

  localparam int unsigned HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_rstart = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_ack, swrst_pulse, holdoff_busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench reference model: 0 idle, 1 expect address, 2 expect command, 3 armed
  int m_st = 0;
  int m_cnt = 0;
  bit m_req = 0;
  string cur_tag = "R1";

  gcr_detector #(.HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rstart(bus_rstart),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ack(rx_ack), .swrst_pulse(swrst_pulse), .holdoff_busy(holdoff_busy)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_ack(input bit v, input logic [7:0] b);
    if (!v) return 0;
    if (m_st == 1) return (b == 8'h00) && (m_cnt == 0);
    if (m_st == 2) return b == 8'h06;
    return 0;
  endfunction

  function automatic string ack_tag(input bit v);
    if (!v) return "R10";
    case (m_st)
      1: return "R2";
      2: return "R4";
      3: return "R7";
      default: return "R1";
    endcase
  endfunction

  // one bus cycle: check registered outputs, drive, check ack, advance model
  task automatic step(input bit s, input bit rs, input bit sp, input bit v, input logic [7:0] b);
    bit fire;
    int nst;
    @(negedge clk);
    chk(swrst_pulse == m_req, (cur_tag == "") ? "R8" : cur_tag, "swrst_pulse", swrst_pulse, m_req);
    chk(holdoff_busy == (m_cnt != 0), "R9", "holdoff_busy", holdoff_busy, (m_cnt != 0));
    bus_start = s; bus_rstart = rs; bus_stop = sp; rx_valid = v; rx_byte = b;
    #1;
    chk(rx_ack == exp_ack(v, b), ack_tag(v), "rx_ack", rx_ack, exp_ack(v, b));
    fire = sp && !(s || rs) && (m_st == 3);
    nst = m_st;
    if (s || rs) nst = 1;
    else if (sp) nst = 0;
    else if (v) begin
      case (m_st)
        1: nst = ((b == 8'h00) && (m_cnt == 0)) ? 2 : 0;
        2: nst = (b == 8'h06) ? 3 : 0;
        default: nst = 0;
      endcase
    end
    m_st = nst;
    m_req = fire;
    if (fire) m_cnt = HOLD;
    else if (m_cnt > 0) m_cnt--;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00);
  endtask

  task automatic by(input logic [7:0] b);
    step(0, 0, 0, 1, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(rx_ack == 0, "R1", "reset rx_ack", rx_ack, 0);
    chk(swrst_pulse == 0, "R1", "reset swrst_pulse", swrst_pulse, 0);
    chk(holdoff_busy == 0, "R1", "reset holdoff_busy", holdoff_busy, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 and R10: bytes before any START, and a 00h with valid low
    cur_tag = "R1"; by(8'h00); by(8'h06); step(0, 0, 1, 0, 8'h00); idle(2);
    step(1, 0, 0, 0, 8'h00); step(0, 0, 0, 0, 8'h00); by(8'h00); step(0, 0, 1, 0, 0); idle(2);

    // R2 R4 R5 R8 R9: full valid sequence, then the whole hold-off window
    cur_tag = "R5";
    step(1, 0, 0, 0, 0); by(8'h00); by(8'h06); step(0, 0, 1, 0, 0);
    cur_tag = "R8"; idle(3);
    // R9: address during hold-off is refused
    cur_tag = "R9"; step(1, 0, 0, 0, 0); by(8'h00); by(8'h06); step(0, 0, 1, 0, 0);
    idle(HOLD + 4);

    // R3: read-direction general call and foreign address
    cur_tag = "R3";
    step(1, 0, 0, 0, 0); by(8'h01); by(8'h06); step(0, 0, 1, 0, 0); idle(2);
    step(1, 0, 0, 0, 0); by(8'h5A); by(8'h06); step(0, 0, 1, 0, 0); idle(2);

    // R4: wrong command byte
    cur_tag = "R4";
    step(1, 0, 0, 0, 0); by(8'h00); by(8'h07); step(0, 0, 1, 0, 0); idle(2);

    // R6: repeated START replaces STOP, and START together with STOP
    cur_tag = "R6";
    step(1, 0, 0, 0, 0); by(8'h00); by(8'h06); step(0, 1, 0, 0, 0); step(0, 0, 1, 0, 0); idle(2);
    step(1, 0, 0, 0, 0); by(8'h00); by(8'h06); step(0, 1, 1, 0, 0); idle(2);
    step(1, 0, 0, 0, 0); by(8'h00); by(8'h06); step(1, 0, 1, 0, 0); idle(2);

    // R7: extra byte after the command
    cur_tag = "R7";
    step(1, 0, 0, 0, 0); by(8'h00); by(8'h06); by(8'h06); step(0, 0, 1, 0, 0); idle(2);

    // R11: stray STOPs
    cur_tag = "R11";
    step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 0); idle(2);

    // R1: START in the middle restarts recognition, then completes
    cur_tag = "R1";
    step(1, 0, 0, 0, 0); by(8'h00); step(1, 0, 0, 0, 0); by(8'h00); by(8'h06); step(0, 0, 1, 0, 0);
    idle(HOLD + 4);

    // constrained random traffic
    cur_tag = "";
    for (int i = 0; i < 6000; i++) begin
      int r;
      int k;
      logic [7:0] b;
      r = $urandom % 16;
      k = $urandom % 4;
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'h06 : (k == 2) ? 8'h01 : 8'($urandom);
      if (r < 2)       step(1, 0, 0, 0, b);
      else if (r == 2) step(0, 1, 0, 0, b);
      else if (r < 5)  step(0, 0, 1, 0, b);
      else if (r < 13) step(0, 0, 0, 1, b);
      else             step(0, 0, 0, 0, b);
    end
    idle(HOLD + 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule